// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition Flags

This block shifts or rotates an 8, 16 or 32-bit operand and produces the five condition flags extend (X), negative (N), zero (Z), overflow (V) and carry (C). It supports eight operations: arithmetic shift left and right, logical shift left and right, plain rotate left and right, and rotate left and right through the extend flag. The operand fetch and the write-back of the result belong to the surrounding datapath. The unit takes one set of inputs on every clock and presents the result and flags one clock later.

The shift count comes from one of three sources. A register value supplies a count of 0 to 63. A 3-bit immediate supplies 1 to 8, where the code zero stands for eight. The single-operand memory form always shifts by one. Each of the three count sources works with each of the eight operations. The flag rules differ by operation. Overflow is raised only by an arithmetic left shift, and only when the sign bit changes at some step. Plain rotates leave X as it was. The through-extend rotates pass data through X as if it were one extra bit of the operand.

Top module: `shrot_unit`

## Requirements
- R1: Every output is registered. The result and flags seen after a rising edge are computed from the inputs sampled at that edge. `op` encodes 0 arithmetic left, 1 arithmetic right, 2 logical left, 3 logical right, 4 rotate left, 5 rotate right, 6 rotate left through X, 7 rotate right through X.
- R2: `size` selects the operand field: 0 byte (bits 7:0), 1 word (bits 15:0), 2 or 3 longword (bits 31:0). Result bits above the field equal the operand's bits.
- R3: `cnt_src` 0 takes the count from `cnt_val` (0 to 63). `cnt_src` 1 takes `cnt_val[2:0]`, with 0 meaning 8. `cnt_src` 2 or 3 shifts by exactly one.
- R4: For the four shift operations, C and X both receive the last bit shifted out. Left shifts fill with zero. A logical right shift fills with zero. An arithmetic right shift repeats the sign bit.
- R5: Plain rotates feed each bit that leaves one end into the other end. C receives the last bit moved, and X keeps the incoming value.
- R6: Through-extend rotates treat X as one extra bit between the two ends. After the operation, both X and C hold the final extend bit.
- R7: With a count of zero, the field is unchanged and X keeps the incoming value. C is cleared, except for the through-extend rotates, where C takes the incoming X.
- R8: V is set by an arithmetic left shift when the field's sign bit takes a different value at any single step. V is 0 for every other operation.
- R9: N equals the top bit of the result field. Z is 1 exactly when the result field is all zeros.
- R10: While `rst_n` is low, the result and all five flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| opnd | input | 32 | Operand |
| size | input | 2 | Operand size select |
| op | input | 3 | Operation select |
| cnt_src | input | 2 | Count source select |
| cnt_val | input | 6 | Register count or immediate code |
| x_in | input | 1 | Incoming extend flag |
| res | output | 32 | Result |
| flag_x | output | 1 | Extend flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The assertions assume that every input is at a defined level at each rising edge once reset is released, since each output is compared with the inputs of the previous cycle. They make no assumption about input encodings, because the reserved size and count-source codes have defined meanings. The stimulus changes inputs only on falling edges and holds every input at a defined value from time zero. A reference model computes the expected result by multiplication and division on integers, and the bench checks the outputs on each falling edge. Directed vectors cover the known byte examples and the count corners: zero, eight, the immediate code for eight, and 63. Random vectors then cover every operation, size and count source.

// File: rtl/shrot_unit.sv
module shrot_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] opnd,
  input  logic [1:0]  size,
  input  logic [2:0]  op,
  input  logic [1:0]  cnt_src,
  input  logic [5:0]  cnt_val,
  input  logic        x_in,
  output logic [31:0] res,
  output logic        flag_x,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_v,
  output logic        flag_c
);
  localparam logic [2:0] OP_ASL = 3'd0, OP_ASR = 3'd1, OP_LSL = 3'd2, OP_LSR = 3'd3,
                         OP_ROL = 3'd4, OP_ROR = 3'd5, OP_RXL = 3'd6, OP_RXR = 3'd7;
  localparam int MAX_STEPS = 63;

  logic [31:0] mask;
  logic [4:0]  msb;
  logic [6:0]  cnt;
  logic [31:0] r;
  logic        x, c, v, hi, lo;

  always_comb begin
    case (size)
      2'd0:    begin mask = 32'h0000_00FF; msb = 5'd7;  end
      2'd1:    begin mask = 32'h0000_FFFF; msb = 5'd15; end
      default: begin mask = 32'hFFFF_FFFF; msb = 5'd31; end
    endcase
  end

  always_comb begin
    case (cnt_src)
      2'd0:    cnt = {1'b0, cnt_val};
      2'd1:    cnt = (cnt_val[2:0] == 3'd0) ? 7'd8 : {4'd0, cnt_val[2:0]};
      default: cnt = 7'd1;
    endcase
  end

  always_comb begin
    r  = opnd & mask;
    x  = x_in;
    c  = (op == OP_RXL || op == OP_RXR) ? x_in : 1'b0;
    v  = 1'b0;
    hi = 1'b0;
    lo = 1'b0;
    for (int i = 0; i < MAX_STEPS; i++) begin
      if (i < int'(cnt)) begin
        hi = r[msb];
        lo = r[0];
        case (op)
          OP_ASL: begin r = (r << 1) & mask; c = hi; x = hi; if (r[msb] != hi) v = 1'b1; end
          OP_ASR: begin r = (r >> 1) | ({31'd0, hi} << msb); c = lo; x = lo; end
          OP_LSL: begin r = (r << 1) & mask; c = hi; x = hi; end
          OP_LSR: begin r = r >> 1; c = lo; x = lo; end
          OP_ROL: begin r = ((r << 1) & mask) | {31'd0, hi}; c = hi; end
          OP_ROR: begin r = (r >> 1) | ({31'd0, lo} << msb); c = lo; end
          OP_RXL: begin r = ((r << 1) & mask) | {31'd0, x}; c = hi; x = hi; end
          default: begin r = (r >> 1) | ({31'd0, x} << msb); c = lo; x = lo; end
        endcase
      end
    end
  end

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0; flag_x <= 1'b0; flag_n <= 1'b0; flag_z <= 1'b0;
      flag_v <= 1'b0; flag_c <= 1'b0; seen <= 1'b0;
    end else begin
      res    <= (opnd & ~mask) | r;
      flag_x <= x;
      flag_n <= r[msb];
      flag_z <= (r == 32'd0);
      flag_v <= v;
      flag_c <= c;
      seen   <= 1'b1;
    end
  end

  p_v_only_asl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(op) != OP_ASL) |-> !flag_v);

  p_rot_keeps_x_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ($past(op) == OP_ROL || $past(op) == OP_ROR)) |-> flag_x == $past(x_in));

  p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(cnt) == 7'd0) |->
      (res == $past(opnd) && flag_x == $past(x_in) &&
       flag_c == (($past(op) == OP_RXL || $past(op) == OP_RXR) && $past(x_in))));

  p_byte_upper_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(size) == 2'd0) |-> res[31:8] == $past(opnd[31:8]));

  p_asr_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(op) == OP_ASR) |-> flag_n == $past(opnd[msb]));

  p_shift_xc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(op) <= OP_LSR && $past(cnt) != 7'd0) |-> flag_x == flag_c);

  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_n |-> (res == 32'd0 && !flag_c && !flag_v));
endmodule

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] opnd = '0;
  logic [1:0]  size = '0;
  logic [2:0]  op = '0;
  logic [1:0]  cnt_src = '0;
  logic [5:0]  cnt_val = '0;
  logic        x_in = 1'b0;
  logic [31:0] res;
  logic        flag_x, flag_n, flag_z, flag_v, flag_c;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shrot_unit dut (.clk(clk), .rst_n(rst_n), .opnd(opnd), .size(size), .op(op),
                  .cnt_src(cnt_src), .cnt_val(cnt_val), .x_in(x_in), .res(res),
                  .flag_x(flag_x), .flag_n(flag_n), .flag_z(flag_z),
                  .flag_v(flag_v), .flag_c(flag_c));

  task automatic model(input logic [31:0] a, input logic [1:0] sz, input logic [2:0] o,
                       input logic [1:0] src, input logic [5:0] cv, input logic xi,
                       output logic [31:0] er, output logic [4:0] ef);
    longint w, top, val, n, b, xx, cc, vv;
    w   = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    top = longint'(1) << w;
    val = longint'(a) % top;
    n   = (src == 0) ? cv : (src == 1) ? ((cv % 8 == 0) ? 8 : cv % 8) : 1;
    xx  = xi;
    cc  = (o >= 6) ? xi : 0;
    vv  = 0;
    for (int k = 0; k < n; k++) begin
      if (o == 0 || o == 2 || o == 4 || o == 6) begin
        b = (val * 2) / top;
        val = (val * 2) % top;
        if (o == 4) val = val + b;
        if (o == 6) begin val = val + xx; end
        if (o == 0 && ((val * 2) / top) != b) vv = 1;
      end else begin
        b = val % 2;
        val = val / 2;
        if (o == 1 && val * 2 >= top / 2) val = val + top / 2;
        if (o == 5 && b == 1) val = val + top / 2;
        if (o == 7 && xx == 1) val = val + top / 2;
      end
      cc = b;
      if (o != 4 && o != 5) xx = b;
    end
    er = (w == 32) ? 32'(val) : ((a / 32'(top)) * 32'(top)) + 32'(val);
    ef = {xx[0], (val * 2 >= top), (val == 0), vv[0], cc[0]};
  endtask

  task automatic step(input logic [31:0] a, input logic [1:0] sz, input logic [2:0] o,
                      input logic [1:0] src, input logic [5:0] cv, input logic xi,
                      input string tag);
    logic [31:0] er;
    logic [4:0]  ef;
    model(a, sz, o, src, cv, xi, er, ef);
    opnd = a; size = sz; op = o; cnt_src = src; cnt_val = cv; x_in = xi;
    @(negedge clk);
    checks++;
    if (res !== er || {flag_x, flag_n, flag_z, flag_v, flag_c} !== ef) begin
      fails++;
      $display("FAIL %s: res=%h xnzvc=%b expected res=%h xnzvc=%b",
               tag, res, {flag_x, flag_n, flag_z, flag_v, flag_c}, er, ef);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    opnd = 32'hDEAD_BEEF; op = 3'd4; cnt_val = 6'd5; x_in = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (res !== 32'd0 || {flag_x, flag_n, flag_z, flag_v, flag_c} !== 5'd0) begin
      fails++;
      $display("FAIL R10: res=%h flags=%b expected 0", res, {flag_x, flag_n, flag_z, flag_v, flag_c});
    end
    rst_n = 1'b1;
    step(32'h0000_00EB, 0, 0, 2, 0, 0, "R1 asl byte");
    step(32'h0000_007E, 0, 0, 2, 0, 0, "R8 asl sign change");
    step(32'h0000_0040, 0, 0, 0, 2, 0, "R8 late sign change");
    step(32'h0000_00EB, 0, 1, 0, 2, 0, "R4 asr twice");
    step(32'h0000_00EB, 0, 3, 2, 0, 0, "R4 lsr");
    step(32'hAB00_00EB, 0, 2, 1, 0, 0, "R3 imm code eight");
    step(32'h1234_8001, 1, 4, 1, 3, 0, "R5 rol word");
    step(32'h8000_0001, 2, 5, 0, 6'd63, 1, "R3 count 63");
    step(32'h0000_0080, 0, 6, 0, 1, 1, "R6 roxl carry in");
    step(32'h0000_0001, 0, 7, 0, 9, 0, "R6 roxr wrap");
    step(32'h5555_0000, 1, 3, 0, 0, 1, "R7 zero count");
    step(32'h0000_0000, 1, 7, 0, 0, 1, "R7 rox zero count");
    step(32'hFFFF_0000, 1, 2, 2, 0, 0, "R9 zero word");
    step(32'h8765_4321, 3, 0, 0, 4, 0, "R2 size code 3");
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] a;
      logic [2:0] o;
      logic [1:0] src;
      logic [5:0] cv;
      string tag;
      a = $urandom; o = 3'($urandom); src = 2'($urandom); cv = 6'($urandom);
      if (src == 0 && cv == 0) tag = "R7";
      else if (o == 0) tag = "R8";
      else if (o >= 6) tag = "R6";
      else if (o >= 4) tag = "R5";
      else tag = "R4";
      step(a, 2'($urandom), o, src, cv, 1'($urandom), tag);
    end
    finish_run();
  end
endmodule